// File: doc/BRIEF.md
# HDLC Bit-Stream Frame Receiver

This block takes a serial line sampled once per bit, signalled by a one-cycle bit enable, and turns it into framed bytes. It first removes NRZI-space line coding. It then watches the decoded bits through a sliding run counter, with no byte alignment, to find opening and closing flags, stuffed zeros and aborts. The data bits that remain are packed into bytes.

Each full byte comes out with a valid strobe. The first byte of a frame also carries a start marker. When the closing flag arrives, an end marker reports how many bits the final partial byte holds (0 to 7). If that count is not zero, the partial byte is delivered in the same cycle, right-aligned. A frame that ends before it fills one whole byte produces nothing at all.

A run of seven ones inside a frame is an abort. After an abort the receiver waits for a new flag. A long run of ones on the line raises an idle level.

Top module: `hdlc_rx`

## Requirements
- R1: The line is decoded NRZI-space. A bit period whose line level equals the previous sampled level is a 1, and a change of level is a 0. The reference level after reset is high.
- R2: Bits received before the first flag (0,1,1,1,1,1,1,0 in time order) produce no output of any kind. A flag is recognised at any bit offset.
- R3: A 0 that follows five consecutive 1s is removed from the data.
- R4: Data bits are packed first-received into bit 0. Each completed byte pulses `byte_valid`. `frame_start` is high only together with the first byte of a frame.
- R5: The closing flag pulses `frame_end`, with `end_bits` equal to the frame length in bits modulo 8. When `end_bits` is not zero, `byte_valid` is high in the same cycle and `byte_data` holds those bits in positions 0 upward.
- R6: A closing flag also opens the next frame, including when its final 0 is shared as the first 0 of a following flag.
- R7: A frame shorter than 8 bits between flags produces no `byte_valid`, `frame_start` or `frame_end`.
- R8: A seventh consecutive 1 inside a frame pulses `abort` and gives no `frame_end`. Every bit after that is ignored until the next flag. Runs of 1s before any flag raise no abort.
- R9: `idle` is high once 15 or more consecutive 1s have been received, and falls after the next 0.
- R10: Every output pulse appears in the cycle after an enabled bit and lasts one cycle. Cycles without `bit_en` change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a valid line sample |
| rx_line | input | 1 | Serial line level, NRZI-space coded |
| byte_valid | output | 1 | Byte (full, or partial with `frame_end`) on `byte_data` |
| byte_data | output | 8 | Received byte, first bit in bit 0 |
| frame_start | output | 1 | First byte of a frame |
| frame_end | output | 1 | Frame closed by a flag |
| end_bits | output | 3 | Number of bits in the final partial byte |
| abort | output | 1 | Frame aborted by a run of seven ones |
| idle | output | 1 | Fifteen or more consecutive ones seen |

## Verification
The hardest case to reach from the ports is the closing flag landing at every offset relative to byte boundaries. In that case the flag's own leading bits must be held back from the data while every genuine data bit before them is still delivered. The bench sends one flag-separated frame of every length from 1 to 40 bits, with content rich in long runs of ones, so that stuffing falls in many positions. The shared-zero flag pair and the hunt period after an abort are reached with hand-placed raw bit sequences that bypass the bench's own stuffing.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_STUFF = 2'd1,
    K_FLAG  = 2'd2,
    K_ABORT = 2'd3
  } bit_kind_t;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_t;
endpackage

// File: rtl/hdlc_rx_nrzi.sv
module hdlc_rx_nrzi #(
  parameter logic REST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_line,
  output logic dec_bit
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (bit_en) prev_d = rx_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= REST_LEVEL;
    else        prev_q <= prev_d;
  end

  assign dec_bit = ~(rx_line ^ prev_q);
endmodule

// File: rtl/hdlc_rx_scan.sv
module hdlc_rx_scan
  import hdlc_rx_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int IDLE_RUN = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      dec_bit,
  output bit_kind_t kind,
  output logic      idle
);
  localparam logic [RUN_W-1:0] STUFF_RUN = RUN_W'(5);
  localparam logic [RUN_W-1:0] FLAG_RUN  = RUN_W'(6);
  localparam logic [RUN_W-1:0] SAT_RUN   = RUN_W'(IDLE_RUN);

  logic [RUN_W-1:0] ones_q, ones_d;

  always_comb begin
    kind = K_DATA;
    if (!dec_bit) begin
      if (ones_q == FLAG_RUN)       kind = K_FLAG;
      else if (ones_q == STUFF_RUN) kind = K_STUFF;
    end else if (ones_q == FLAG_RUN) begin
      kind = K_ABORT;
    end
  end

  always_comb begin
    ones_d = ones_q;
    if (bit_en) begin
      if (!dec_bit)               ones_d = '0;
      else if (ones_q != SAT_RUN) ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign idle = (ones_q >= SAT_RUN);

  AST_IDLE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(bit_en && dec_bit)); // R9
  AST_IDLE_ENDS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !dec_bit) |=> !idle); // R9
endmodule

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int GUARD  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              dec_bit,
  input  bit_kind_t         kind,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_start,
  output logic              frame_end,
  output logic [$clog2(BYTE_W)-1:0] end_bits,
  output logic              abort
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int DLY_W = $clog2(GUARD + 1);
  localparam logic [DLY_W-1:0] DLY_FULL = DLY_W'(GUARD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  rx_state_t         st_q, st_d;
  logic [GUARD-1:0]  dly_q, dly_d;
  logic [DLY_W-1:0]  dn_q, dn_d;
  logic [BYTE_W-1:0] asm_q, asm_d, asm_in;
  logic [CNT_W-1:0]  an_q, an_d;
  logic              started_q, started_d;
  logic              bv_q, bv_d, sof_q, sof_d, eof_q, eof_d, ab_q, ab_d;
  logic [BYTE_W-1:0] bd_q, bd_d;
  logic [CNT_W-1:0]  eb_q, eb_d;
  logic [CNT_W:0]    align_sh;

  assign asm_in   = {dly_q[0], asm_q[BYTE_W-1:1]};
  assign align_sh = (CNT_W+1)'(BYTE_W) - {1'b0, an_q};

  always_comb begin
    st_d      = st_q;
    dly_d     = dly_q;
    dn_d      = dn_q;
    asm_d     = asm_q;
    an_d      = an_q;
    started_d = started_q;
    bv_d      = 1'b0;
    sof_d     = 1'b0;
    eof_d     = 1'b0;
    ab_d      = 1'b0;
    bd_d      = bd_q;
    eb_d      = '0;
    if (bit_en) begin
      if (st_q == ST_HUNT) begin
        if (kind == K_FLAG) begin
          st_d      = ST_FRAME;
          dn_d      = '0;
          an_d      = '0;
          started_d = 1'b0;
        end
      end else begin
        case (kind)
          K_FLAG: begin
            if (started_q) begin
              eof_d = 1'b1;
              eb_d  = an_q;
              bv_d  = (an_q != '0);
              bd_d  = asm_q >> align_sh;
            end
            dn_d      = '0;
            an_d      = '0;
            started_d = 1'b0;
          end
          K_ABORT: begin
            ab_d      = 1'b1;
            st_d      = ST_HUNT;
            dn_d      = '0;
            an_d      = '0;
            started_d = 1'b0;
          end
          K_DATA: begin
            dly_d = {dec_bit, dly_q[GUARD-1:1]};
            if (dn_q == DLY_FULL) begin
              asm_d = asm_in;
              if (an_q == CNT_LAST) begin
                bv_d      = 1'b1;
                bd_d      = asm_in;
                sof_d     = !started_q;
                started_d = 1'b1;
                an_d      = '0;
              end else begin
                an_d = an_q + 1'b1;
              end
            end else begin
              dn_d = dn_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      dly_q     <= '0;
      dn_q      <= '0;
      asm_q     <= '0;
      an_q      <= '0;
      started_q <= 1'b0;
      bv_q      <= 1'b0;
      sof_q     <= 1'b0;
      eof_q     <= 1'b0;
      ab_q      <= 1'b0;
      bd_q      <= '0;
      eb_q      <= '0;
    end else begin
      st_q      <= st_d;
      dly_q     <= dly_d;
      dn_q      <= dn_d;
      asm_q     <= asm_d;
      an_q      <= an_d;
      started_q <= started_d;
      bv_q      <= bv_d;
      sof_q     <= sof_d;
      eof_q     <= eof_d;
      ab_q      <= ab_d;
      bd_q      <= bd_d;
      eb_q      <= eb_d;
    end
  end

  assign byte_valid  = bv_q;
  assign byte_data   = bd_q;
  assign frame_start = sof_q;
  assign frame_end   = eof_q;
  assign end_bits    = eb_q;
  assign abort       = ab_q;

  AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> bv_q); // R4
  AST_PARTIAL_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_q && eb_q != '0) |-> bv_q); // R5
  AST_STUFF_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && kind == K_STUFF) |=> !bv_q); // R3
  AST_ABORT_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof_q && ab_q)); // R8
  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st_q == ST_HUNT) |=> !(bv_q || eof_q || ab_q)); // R2
  AST_PULSE_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_q || eof_q || ab_q) |-> $past(bit_en)); // R10
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int RUN_W    = 4,
  parameter int IDLE_RUN = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_line,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_start,
  output logic              frame_end,
  output logic [$clog2(BYTE_W)-1:0] end_bits,
  output logic              abort,
  output logic              idle
);
  logic      dec_bit;
  bit_kind_t kind;

  hdlc_rx_nrzi #(.REST_LEVEL(1'b1)) u_nrzi (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_line(rx_line), .dec_bit(dec_bit)
  );

  hdlc_rx_scan #(.RUN_W(RUN_W), .IDLE_RUN(IDLE_RUN)) u_scan (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dec_bit(dec_bit),
    .kind(kind), .idle(idle)
  );

  hdlc_rx_deframe #(.BYTE_W(BYTE_W), .GUARD(7)) u_deframe (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dec_bit(dec_bit), .kind(kind),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_start(frame_start),
    .frame_end(frame_end), .end_bits(end_bits), .abort(abort)
  );
endmodule

// File: tb/hdlc_rx_bench.sv
module hdlc_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, rx_line;
  logic       byte_valid, frame_start, frame_end, abort, idle;
  logic [7:0] byte_data;
  logic [2:0] end_bits;

  int checks = 0;
  int errors = 0;
  logic line_lvl;
  int ones_tx;
  int got_n, sof_cnt, sof_bad, eof_cnt, abort_cnt, gap_bad;
  logic [7:0] got [0:63];
  logic [2:0] eof_b;
  logic [7:0] eof_byte;
  logic       eof_bv;

  always #4 clk = ~clk;

  hdlc_rx u_hdlc_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_line(rx_line),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_start(frame_start),
    .frame_end(frame_end), .end_bits(end_bits), .abort(abort), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_rec();
    got_n = 0; sof_cnt = 0; sof_bad = 0; eof_cnt = 0; abort_cnt = 0;
    eof_b = '0; eof_byte = '0; eof_bv = 1'b0;
  endtask

  task automatic raw_bit(input logic b);
    @(negedge clk);
    if (byte_valid || frame_end || abort) gap_bad++;
    if (!b) line_lvl = ~line_lvl;
    rx_line = line_lvl;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if (byte_valid && !frame_end) begin
      if (frame_start) begin
        sof_cnt++;
        if (got_n != 0) sof_bad++;
      end
      if (got_n < 64) got[got_n] = byte_data;
      got_n++;
    end
    if (frame_end) begin
      eof_cnt++;
      eof_b = end_bits; eof_bv = byte_valid; eof_byte = byte_data;
    end
    if (abort) abort_cnt++;
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin
        raw_bit(1'b0);
        ones_tx = 0;
      end
    end else begin
      ones_tx = 0;
    end
  endtask

  task automatic send_flag();
    raw_bit(1'b0);
    for (int k = 0; k < 6; k++) raw_bit(1'b1);
    raw_bit(1'b0);
    ones_tx = 0;
  endtask

  function automatic logic fbit(input int len, input int i);
    if (((i + len) % 9) < 7) return 1'b1;
    return ((i * len) % 3) == 0;
  endfunction

  task automatic send_data(input int len);
    for (int i = 0; i < len; i++) data_bit(fbit(len, i));
  endtask

  task automatic check_frame(input int len);
    int nb, res, bad;
    logic [7:0] e;
    nb = len / 8; res = len % 8; bad = 0;
    if (len < 8) begin
      chk(got_n == 0 && sof_cnt == 0 && eof_cnt == 0, "R7",
          $sformatf("short frame %0d bits, outputs", len), got_n + eof_cnt, 0);
    end else begin
      chk(got_n == nb, "R4", $sformatf("byte count len %0d", len), got_n, nb);
      for (int k = 0; k < nb && k < got_n; k++) begin
        for (int j = 0; j < 8; j++) e[j] = fbit(len, 8 * k + j);
        if (got[k] != e) bad++;
      end
      chk(bad == 0, "R1/R3", $sformatf("byte content len %0d", len), bad, 0);
      chk(sof_cnt == 1 && sof_bad == 0, "R4", $sformatf("start marker len %0d", len),
          sof_cnt, 1);
      chk(eof_cnt == 1, "R5", $sformatf("end count len %0d", len), eof_cnt, 1);
      chk(int'(eof_b) == res, "R5", $sformatf("end_bits len %0d", len), eof_b, res);
      if (res != 0) begin
        e = '0;
        for (int j = 0; j < res; j++) e[j] = fbit(len, 8 * nb + j);
        chk(eof_bv && eof_byte == e, "R5", $sformatf("partial byte len %0d", len),
            eof_byte, e);
      end else begin
        chk(!eof_bv, "R5", $sformatf("no partial len %0d", len), eof_bv, 0);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_line = 1'b1; line_lvl = 1'b1;
    ones_tx = 0; gap_bad = 0;
    clear_rec();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!byte_valid && !frame_start && !frame_end && !abort && !idle, "R10",
        "reset outputs", byte_valid + frame_end + abort + idle, 0);

    // R9 / R1: a steady line decodes as ones, idle after the fifteenth
    for (int k = 0; k < 14; k++) raw_bit(1'b1);
    chk(!idle, "R9", "idle after 14 ones", idle, 0);
    raw_bit(1'b1);
    chk(idle, "R9", "idle after 15 ones", idle, 1);
    raw_bit(1'b0);
    chk(!idle, "R9", "idle after zero", idle, 0);
    chk(abort_cnt == 0, "R8", "no abort before a flag", abort_cnt, 0);

    // R2: noise before the first flag
    for (int k = 0; k < 21; k++) raw_bit(((k % 4) != 2));
    chk(got_n == 0 && eof_cnt == 0 && sof_cnt == 0, "R2", "pre-flag output",
        got_n + eof_cnt, 0);

    // R4 R5 R6 R7: frames of every length, each closing flag opens the next
    send_flag();
    for (int len = 1; len <= 40; len++) begin
      clear_rec();
      send_data(len);
      send_flag();
      check_frame(len);
    end

    // R6: flags sharing one zero
    clear_rec();
    send_data(16);
    raw_bit(1'b0);
    for (int k = 0; k < 6; k++) raw_bit(1'b1);
    raw_bit(1'b0);
    for (int k = 0; k < 6; k++) raw_bit(1'b1);
    raw_bit(1'b0);
    ones_tx = 0;
    check_frame(16);
    clear_rec();
    send_data(20);
    send_flag();
    chk(got_n == 2 && eof_cnt == 1, "R6", "frame after shared-zero flags",
        got_n, 2);
    check_frame(20);

    // R8: abort, hunt, recovery
    clear_rec();
    send_data(16);
    raw_bit(1'b0);
    for (int k = 0; k < 7; k++) raw_bit(1'b1);
    chk(abort_cnt == 1, "R8", "abort pulses", abort_cnt, 1);
    chk(eof_cnt == 0, "R8", "no end after abort", eof_cnt, 0);
    clear_rec();
    for (int k = 0; k < 32; k++) raw_bit(((k % 5) < 3));
    chk(got_n == 0 && eof_cnt == 0 && abort_cnt == 0, "R8", "hunt after abort",
        got_n + eof_cnt + abort_cnt, 0);
    send_flag();
    clear_rec();
    send_data(24);
    send_flag();
    check_frame(24);

    chk(gap_bad == 0, "R10", "pulses in cycles without bit_en", gap_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule